// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches the already-synchronized input levels of up to 32 port pins and turns configured activity on them into interrupt requests. Each pin owns a control word in which a 4-bit mode field picks what counts as an event for that pin. The available events are:

- a rising transition
- a falling transition
- either transition
- the pin sitting low
- the pin sitting high

A zero mode field disables the pin.

Every detected event latches a per-pin flag in one shared status word. Software finds out which pins fired by reading that word, and clears individual flags by writing ones to them. A single registered interrupt line is asserted while any flag is pending.

Configuration and status go through a simple register bus. Writes take effect on the clock edge. Read data is returned combinationally from the stored state.

Top module: `gpirq_ctrl`

## Requirements
- R1: After reset every pin's mode is off (control readback 0), the status word reads 0 and `irq_o` is 0.
- R2: A write to byte address 4*n (n below NPINS) stores bits 19:16 of the write data as pin n's mode. Reading that address returns the mode in bits 19:16 and zeros in every other bit.
- R3: Mode 0x9 (rising) sets pin n's flag when the pin is 0 in one cycle and 1 in the next. A falling transition in this mode sets nothing.
- R4: Mode 0xA (falling) sets the flag on a 1-to-0 transition only.
- R5: Mode 0xB (either) sets the flag on any change of the pin level.
- R6: Mode 0x8 (level low) sets the flag on every cycle the pin is 0. A clear while the pin stays low leaves the flag set.
- R7: Mode 0xC (level high) sets the flag on every cycle the pin is 1.
- R8: Mode 0x0 and every code other than 0x8 to 0xC never set a flag. Writing 0 to a control word turns that pin off.
- R9: A write to address 0xA0 clears each flag whose write-data bit is 1 and leaves the flags under 0 bits unchanged. Writing all ones clears every flag.
- R10: When a clear of a flag and a new event on the same pin fall in the same cycle, the flag ends up set.
- R11: `irq_o` equals the OR of all flags as they were one clock earlier.
- R12: Reading address 0xA0 returns the status word, with bit n holding pin n's flag.
- R13: Writes to addresses that are neither 0xA0 nor an aligned control word 4*n change no mode and no flag. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NPINS | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 pins, an 8-bit address and a 32-bit data word. With these, the highest control word at 0x7C sits directly below the unmapped gap up to 0x9C, and the status word uses all 32 data bits. This puts the last pin, the first unmapped slot above it and every status bit position within reach of a directed test. A behavioural model advanced on every clock also checks the combined line and the readback against each mode, including a clear that lands on the same cycle as an event.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        TRIG_NONE   = 4'h0,
        TRIG_LOW    = 4'h8,
        TRIG_RISE   = 4'h9,
        TRIG_FALL   = 4'hA,
        TRIG_ANY    = 4'hB,
        TRIG_HIGH   = 4'hC
    } trig_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              prev;
    } pin_state_t;

    function automatic logic trig_hit(logic [MODE_W-1:0] mode, logic cur, logic last);
        logic hit;
        case (mode)
            TRIG_LOW:  hit = ~cur;
            TRIG_RISE: hit = cur & ~last;
            TRIG_FALL: hit = ~cur & last;
            TRIG_ANY:  hit = cur ^ last;
            TRIG_HIGH: hit = cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpirq_pin.sv
module gpirq_pin
    import gpirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic              wr_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              evt_o,
    output logic [MODE_W-1:0] mode_o
);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
        if (wr_i) begin
            st_d.mode = mode_i;
        end
        evt_o  = trig_hit(st_q.mode, pin_i, st_q.prev);
        mode_o = st_q.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gpirq_flags.sv
module gpirq_flags #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] evt_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] flags_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [NPINS-1:0] flags;
        logic             irq;
    } flag_state_t;

    flag_state_t fs_d, fs_q;

    always_comb begin
        fs_d.flags = (fs_q.flags & ~clr_i) | evt_i;
        fs_d.irq   = |fs_q.flags;
        flags_o    = fs_q.flags;
        irq_o      = fs_q.irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

endmodule

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl
    import gpirq_pkg::*;
#(
    parameter int              NPINS    = 32,
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter int              MODE_LSB = 16,
    parameter logic [7:0]      STAT_OFS = 8'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

    logic [NPINS-1:0]  evt_w;
    logic [NPINS-1:0]  clr_w;
    logic [NPINS-1:0]  flags_w;
    logic [MODE_W-1:0] mode_w [NPINS];
    logic              stat_sel;

    assign stat_sel = (bus_addr == STAT_ADDR);
    assign clr_w    = (bus_we && stat_sel) ? bus_wdata[NPINS-1:0] : '0;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic slot_wr;
        assign slot_wr = bus_we && (bus_addr == ADDR_W'(4 * g));
        gpirq_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_i[g]),
            .wr_i   (slot_wr),
            .mode_i (bus_wdata[MODE_LSB +: MODE_W]),
            .evt_o  (evt_w[g]),
            .mode_o (mode_w[g])
        );
    end

    gpirq_flags #(.NPINS(NPINS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_w),
        .clr_i   (clr_w),
        .flags_o (flags_w),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (stat_sel) begin
            bus_rdata[NPINS-1:0] = flags_w;
        end
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == ADDR_W'(4 * i)) begin
                bus_rdata[MODE_LSB +: MODE_W] = mode_w[i];
            end
        end
    end

endmodule

// File: rtl/gpirq_ctrl_chk.sv
module gpirq_ctrl_chk #(
    parameter int         NPINS    = 32,
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 32,
    parameter logic [7:0] STAT_OFS = 8'hA0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  flags,
    input logic [NPINS-1:0]  evt,
    input logic              irq_o
);

    logic              stat_wr;
    logic [NPINS-1:0]  wmask;

    assign stat_wr = bus_we && (bus_addr == ADDR_W'(STAT_OFS));
    assign wmask   = stat_wr ? bus_wdata[NPINS-1:0] : '0;

    // R11: combined line follows the flags of the previous cycle
    p_irq_or_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == (|$past(flags))));

    // R9: written ones clear their flags unless an event refills them
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((flags & $past(bus_wdata[NPINS-1:0] & ~evt)) == '0));

    // R9: flags not targeted by a clear stay set
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~wmask)) == $past(flags & ~wmask)));

    // R10: an event always lands in the status word, even against a clear
    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(evt)) == $past(evt)));

endmodule

bind gpirq_ctrl gpirq_ctrl_chk #(
    .NPINS    (NPINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_OFS (STAT_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags     (flags_w),
    .evt       (evt_w),
    .irq_o     (irq_o)
);

// File: tb/gpirq_ctrl_bench.sv
module gpirq_ctrl_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         NP   = 32;
    localparam int         AW   = 8;
    localparam int         DW   = 32;
    localparam logic [7:0] STAT = 8'hA0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = STAT;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpirq_ctrl u_gpirq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pins),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // behavioural reference
    logic [31:0] m_flags;
    logic        m_irq;
    logic [31:0] m_prev;
    int          m_mode [NP];

    function automatic bit m_hit(int mode, bit cur, bit last);
        if (mode == 8)  return !cur;
        if (mode == 9)  return cur && !last;
        if (mode == 10) return !cur && last;
        if (mode == 11) return cur != last;
        if (mode == 12) return cur;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int ai;
        ai = int'(a);
        if (a == STAT) return m_flags;
        if (ai % 4 == 0 && ai / 4 < NP) return 32'(m_mode[ai / 4]) << 16;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_flags = '0;
            m_irq   = 1'b0;
            m_prev  = '0;
            for (int i = 0; i < NP; i++) m_mode[i] = 0;
        end else begin
            logic [31:0] ev;
            logic [31:0] clr;
            int ai;
            for (int i = 0; i < NP; i++) ev[i] = m_hit(m_mode[i], pins[i], m_prev[i]);
            clr = (bus_we && bus_addr == STAT) ? bus_wdata : 32'h0;
            m_irq   = |m_flags;
            m_flags = (m_flags & ~clr) | ev;
            ai = int'(bus_addr);
            if (bus_we && ai % 4 == 0 && ai / 4 < NP) m_mode[ai / 4] = int'(bus_wdata[19:16]);
            m_prev = pins;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model comparison on every clock
    always @(negedge clk) begin
        if (running && !rst) begin
            chk("R11 irq vs model", {31'h0, irq_o}, {31'h0, m_irq});
            chk("R12/R2 readback vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = STAT; bus_wdata = '0;
    endtask

    task automatic setpin(int idx, logic v);
        @(negedge clk); #1;
        pins[idx] = v;
    endtask

    task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
        bus_addr = STAT; #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int codes [5] = '{1, 5, 7, 13, 15};
        repeat (3) @(negedge clk);
        #1; rst = 1'b0; running = 1'b1;
        tick(1);

        // R1 reset state
        rd(STAT, "R1 status", 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        rd(8'h00, "R1 ctrl0", 32'h0);

        // R2 mode store and readback
        wr(8'h0C, 32'hFFF9_FFFF);
        rd(8'h0C, "R2 ctrl3", 32'h0009_0000);

        // R3 rising
        setpin(3, 1'b1); tick(1);
        rd(STAT, "R3 rise", 32'h8);
        tick(1);
        chk("R11 irq high", {31'h0, irq_o}, 32'h1);
        setpin(3, 1'b0); tick(2);
        rd(STAT, "R3 fall ignored", 32'h8);

        // R9 clear, R11 drop
        wr(STAT, 32'h8); tick(1);
        rd(STAT, "R9 cleared", 32'h0);
        chk("R11 irq low", {31'h0, irq_o}, 32'h0);

        // R4 falling
        wr(8'h14, 32'h000A_0000);
        setpin(5, 1'b1); tick(2);
        rd(STAT, "R4 rise ignored", 32'h0);
        setpin(5, 1'b0); tick(1);
        rd(STAT, "R4 fall", 32'h20);

        // R5 either
        wr(8'h1C, 32'h000B_0000);
        setpin(7, 1'b1); tick(1);
        rd(STAT, "R5 rise", 32'hA0);
        wr(STAT, 32'h80);
        setpin(7, 1'b0); tick(1);
        rd(STAT, "R5 fall", 32'hA0);

        // R9 partial and full clears
        wr(STAT, 32'h0);
        rd(STAT, "R9 zero write", 32'hA0);
        wr(STAT, 32'h20);
        rd(STAT, "R9 single bit", 32'h80);
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, "R9 all ones", 32'h0);

        // R6 level low
        wr(8'h24, 32'h0008_0000); tick(1);
        rd(STAT, "R6 low sets", 32'h200);
        wr(STAT, 32'h200);
        rd(STAT, "R6 resets after clear", 32'h200);
        setpin(9, 1'b1); tick(1);
        wr(STAT, 32'h200);
        rd(STAT, "R6 released", 32'h0);

        // R7 level high
        wr(8'h28, 32'h000C_0000); tick(2);
        rd(STAT, "R7 low ignored", 32'h0);
        setpin(10, 1'b1); tick(1);
        rd(STAT, "R7 high sets", 32'h400);
        wr(8'h28, 32'h0);
        wr(STAT, 32'h400); tick(1);
        rd(STAT, "R8 zero write turns off", 32'h0);

        // R8 reserved codes
        for (int k = 0; k < 5; k++) begin
            wr(8'h2C, 32'(codes[k]) << 16);
            setpin(11, 1'b1); tick(1);
            setpin(11, 1'b0); tick(1);
            rd(STAT, "R8 reserved", 32'h0);
        end

        // R10 clear and event together
        wr(8'h30, 32'h0009_0000);
        setpin(12, 1'b1); tick(1);
        rd(STAT, "R10 setup", 32'h1000);
        setpin(12, 1'b0); tick(1);
        @(negedge clk); #1;
        pins[12] = 1'b1; bus_we = 1'b1; bus_addr = STAT; bus_wdata = 32'h1000;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
        rd(STAT, "R10 event wins", 32'h1000);
        wr(STAT, 32'hFFFF_FFFF);

        // R13 unmapped writes
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h9C, 32'hFFFF_FFFF);
        wr(8'hA4, 32'hFFFF_FFFF);
        wr(8'h0D, 32'h0);
        rd(8'h80, "R13 gap read", 32'h0);
        rd(8'hA4, "R13 above status", 32'h0);
        rd(8'h0C, "R13 unaligned ignored", 32'h0009_0000);
        rd(STAT, "R13 flags untouched", 32'h0);

        // last pin, R12 top status bit
        wr(8'h7C, 32'h0009_0000);
        rd(8'h7C, "R2 ctrl31", 32'h0009_0000);
        setpin(31, 1'b1); tick(1);
        rd(STAT, "R12 bit31", 32'h8000_0000);
        tick(2);

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule